// File: doc/BRIEF.md
# Four-Digit Hex Display Scanner

This block drives four seven-segment digits that share one set of segment lines and are selected by separate anode lines. A free-running prescaler counts master clock cycles. Each time a chosen prescaler bit rises, a two-bit digit pointer steps to the next position. The pointer picks one 4-bit nibble out of a 16-bit input word. That nibble is decoded to active-low segment levels, and the anode for the same position is lit. When the scan rate is well above the flicker threshold, all four digits appear to be on at the same time.

Each position has its own enable bit. A cleared bit keeps that position's anode dark for its whole time slot. The prescaler tap is a parameter. The default tap gives roughly 50 MHz / 2^18 from a 50 MHz master clock, and a simulation can choose a much shorter scan period. A single asynchronous active-high clear returns both the prescaler and the pointer to zero.

Top module: `hexscan_top`

## Requirements
- R1: While `clr` is high, the pointer is forced to position 0 without waiting for a clock edge, and the prescaler is forced to zero.
- R2: After `clr` falls, the pointer first advances on the 2^TAP-th rising clock edge. After that it advances once every 2^(TAP+1) edges, on the edge where prescaler bit TAP goes from 0 to 1.
- R3: The pointer counts 0, 1, 2, 3 and then wraps to 0. Position p drives the anode bit with index 3-p, so the anode order is 4'b1000, 4'b0100, 4'b0010, 4'b0001.
- R4: An anode bit can be 1 only while `dig_en` has the bit with the same index set. In a slot whose position is disabled, `anode` is 4'b0000.
- R5: `seg_n` is active low, with `seg_n[6]`=a through `seg_n[0]`=g. Hex values 0-F light these segments (lit, abcdefg): 0=1111110, 1=0110000, 2=1101101, 3=1111001, 4=0110011, 5=1011011, 6=1011111, 7=1110000, 8=1111111, 9=1111011, A=1110111, b=0011111, C=1001110, d=0111101, E=1001111, F=1000111.
- R6: In a slot that drives anode bit i, the decoded nibble is `value[4*i+3:4*i]`. The digit on anode 4'b1000 therefore shows the most significant nibble. Segments are decoded whether or not the position is enabled.
- R7: At most one anode bit is 1 at any time.
- R8: `seg_n` and `anode` depend on `value` and `dig_en` without a register in between. A change to either input shows within the current slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| clr | input | 1 | Asynchronous active-high clear of prescaler and pointer |
| value | input | 16 | Four hex nibbles; bits 15:12 shown on anode bit 3 |
| dig_en | input | 4 | Per-position enable, bit i gates anode bit i |
| anode | output | 4 | Digit select, 1 = digit lit |
| seg_n | output | 7 | Segments a (bit 6) to g (bit 0), 0 = lit |

## Verification
The checker's properties sample `value` and `dig_en` on the rising clock edge and assume both are steady there. The step and phase properties assume that `clr` is low for the whole of each counting interval they look at. The bench changes `value`, `dig_en` and `clr` only shortly after a falling edge, so every rising edge sees settled inputs. It releases `clr` at a falling edge, so the first counted rising edge is well defined. The one deliberate exception is the check that `clr` acts without a clock: there, `clr` is raised between edges and the outputs are read before the next rising edge.

// File: rtl/hexscan_pkg.sv
package hexscan_pkg;

   localparam int unsigned SEG_W = 7;
   localparam int unsigned HEX_W = 4;

   // Returns active-low segment levels, bit 6 = a ... bit 0 = g.
   function automatic logic [SEG_W-1:0] hex_to_seg_n(input logic [HEX_W-1:0] nib);
      logic [SEG_W-1:0] lit;
      unique case (nib)
         4'h0: lit = 7'b1111110;
         4'h1: lit = 7'b0110000;
         4'h2: lit = 7'b1101101;
         4'h3: lit = 7'b1111001;
         4'h4: lit = 7'b0110011;
         4'h5: lit = 7'b1011011;
         4'h6: lit = 7'b1011111;
         4'h7: lit = 7'b1110000;
         4'h8: lit = 7'b1111111;
         4'h9: lit = 7'b1111011;
         4'hA: lit = 7'b1110111;
         4'hB: lit = 7'b0011111;
         4'hC: lit = 7'b1001110;
         4'hD: lit = 7'b0111101;
         4'hE: lit = 7'b1001111;
         default: lit = 7'b1000111;
      endcase
      return ~lit;
   endfunction

endpackage

// File: rtl/hexscan_div.sv
// Free-running prescaler; only the bits up to and including the tap exist.
module hexscan_div #(
   parameter int unsigned TAP = 17
) (
   input  logic         clk,
   input  logic         clr,
   output logic [TAP:0] phase
);

   always_ff @(posedge clk or posedge clr) begin
      if (clr) phase <= '0;
      else     phase <= phase + 1'b1;
   end

endmodule

// File: rtl/hexscan_ptr.sv
// Digit pointer: wrapping up-counter with asynchronous clear.
module hexscan_ptr #(
   parameter int unsigned PTR_W = 2
) (
   input  logic             clk,
   input  logic             clr,
   input  logic             adv,
   output logic [PTR_W-1:0] ptr
);

   always_ff @(posedge clk or posedge clr) begin
      if (clr)      ptr <= '0;
      else if (adv) ptr <= ptr + 1'b1;
   end

endmodule

// File: rtl/hexscan_sel.sv
// Position-to-anode encoder (reversed order) with enable gating and nibble mux.
module hexscan_sel #(
   parameter int unsigned NDIG  = 4,
   parameter int unsigned NIB_W = 4,
   parameter int unsigned PTR_W = 2
) (
   input  logic [PTR_W-1:0]      ptr,
   input  logic [NDIG*NIB_W-1:0] value,
   input  logic [NDIG-1:0]       en,
   output logic [NDIG-1:0]       anode,
   output logic [NIB_W-1:0]      nib
);

   logic [NDIG-1:0] hit;

   for (genvar g = 0; g < NDIG; g++) begin : g_slot
      localparam logic [PTR_W-1:0] POS = PTR_W'(NDIG - 1 - g);
      assign hit[g]   = (ptr == POS);
      assign anode[g] = hit[g] & en[g];
   end

   always_comb begin
      nib = '0;
      for (int i = 0; i < NDIG; i++) begin
         if (hit[i]) nib = value[i*NIB_W +: NIB_W];
      end
   end

endmodule

// File: rtl/hexscan_top.sv
module hexscan_top #(
   parameter int unsigned DIV_W = 24,
   parameter int unsigned TAP   = 17,
   parameter int unsigned NDIG  = 4
) (
   input  logic                                   clk,
   input  logic                                   clr,
   input  logic [NDIG*hexscan_pkg::HEX_W-1:0]     value,
   input  logic [NDIG-1:0]                        dig_en,
   output logic [NDIG-1:0]                        anode,
   output logic [hexscan_pkg::SEG_W-1:0]          seg_n
);
   import hexscan_pkg::*;

   localparam int unsigned PTR_W = (NDIG > 1) ? $clog2(NDIG) : 1;
   localparam logic [TAP:0] PRE_PH = {1'b0, {TAP{1'b1}}};

   if (TAP < 1 || TAP >= DIV_W) begin : g_bad_tap
      $error("hexscan_top: TAP must lie in 1..DIV_W-1");
   end
   if (NDIG < 2 || (1 << PTR_W) != NDIG) begin : g_bad_ndig
      $error("hexscan_top: NDIG must be a power of two, at least 2");
   end

   logic [TAP:0]       phase;
   logic               adv;
   logic [PTR_W-1:0]   ptr_q;
   logic [HEX_W-1:0]   nib;

   hexscan_div #(.TAP(TAP)) div_i (
      .clk   (clk),
      .clr   (clr),
      .phase (phase)
   );

   // Step on the edge where the tap bit rises.
   assign adv = (phase == PRE_PH);

   hexscan_ptr #(.PTR_W(PTR_W)) ptr_i (
      .clk (clk),
      .clr (clr),
      .adv (adv),
      .ptr (ptr_q)
   );

   hexscan_sel #(.NDIG(NDIG), .NIB_W(HEX_W), .PTR_W(PTR_W)) sel_i (
      .ptr   (ptr_q),
      .value (value),
      .en    (dig_en),
      .anode (anode),
      .nib   (nib)
   );

   assign seg_n = hex_to_seg_n(nib);

endmodule

// File: rtl/hexscan_chk.sv
module hexscan_chk #(
   parameter int unsigned NDIG  = 4,
   parameter int unsigned PTR_W = 2,
   parameter int unsigned TAP   = 17,
   parameter int unsigned VAL_W = 16
) (
   input logic             clk,
   input logic             clr,
   input logic [PTR_W-1:0] ptr,
   input logic [TAP:0]     phase,
   input logic [NDIG-1:0]  anode,
   input logic [NDIG-1:0]  dig_en,
   input logic [VAL_W-1:0] value,
   input logic [6:0]       seg_n
);

   localparam logic [TAP:0] EDGE_PH = {1'b1, {TAP{1'b0}}};

   // R1
   clr_home_chk: assert property (@(posedge clk) clr |-> (ptr == '0 && phase == '0));

   // R2
   step_phase_chk: assert property (@(posedge clk) disable iff (clr)
      (ptr != $past(ptr)) |-> (phase == EDGE_PH));

   // R3
   step_inc_chk: assert property (@(posedge clk) disable iff (clr)
      (ptr != $past(ptr)) |-> (ptr == PTR_W'($past(ptr) + 1'b1)));

   // R3
   anode_pos_chk: assert property (@(posedge clk) disable iff (clr)
      (anode != '0) |-> (anode == (NDIG'(1) << (NDIG - 1 - ptr))));

   // R4
   en_gate_chk: assert property (@(posedge clk) disable iff (clr)
      ((anode & ~dig_en) == '0));

   // R7
   one_anode_chk: assert property (@(posedge clk) disable iff (clr) $onehot0(anode));

   // R8
   seg_hold_chk: assert property (@(posedge clk) disable iff (clr)
      ($stable(ptr) && $stable(value)) |-> $stable(seg_n));

endmodule

bind hexscan_top hexscan_chk #(
   .NDIG (NDIG),
   .PTR_W(PTR_W),
   .TAP  (TAP),
   .VAL_W(NDIG*4)
) chk_i (
   .clk   (clk),
   .clr   (clr),
   .ptr   (ptr_q),
   .phase (phase),
   .anode (anode),
   .dig_en(dig_en),
   .value (value),
   .seg_n (seg_n)
);

// File: tb/hexscan_top_tb.sv
module hexscan_top_tb_top;

   localparam int TAP  = 2;
   localparam int HALF = 1 << TAP;

   logic        clk = 1'b0;
   logic        clr = 1'b1;
   logic [15:0] value = 16'h0000;
   logic [3:0]  dig_en = 4'b1111;
   logic [3:0]  anode;
   logic [6:0]  seg_n;

   int n_chk = 0;
   int n_bad = 0;
   int k = 0;
   bit done = 0;

   always #4 clk = ~clk;

   // Bench model of edges counted since clear release.
   always @(posedge clk or posedge clr) begin
      if (clr) k <= 0;
      else     k <= k + 1;
   end

   hexscan_top #(.TAP(TAP)) dut_i (
      .clk(clk), .clr(clr), .value(value), .dig_en(dig_en),
      .anode(anode), .seg_n(seg_n)
   );

   function automatic logic [6:0] ref_seg(input logic [3:0] n);
      logic [6:0] lit;
      case (n)
         4'h0: lit = 7'b1111110;  4'h1: lit = 7'b0110000;
         4'h2: lit = 7'b1101101;  4'h3: lit = 7'b1111001;
         4'h4: lit = 7'b0110011;  4'h5: lit = 7'b1011011;
         4'h6: lit = 7'b1011111;  4'h7: lit = 7'b1110000;
         4'h8: lit = 7'b1111111;  4'h9: lit = 7'b1111011;
         4'hA: lit = 7'b1110111;  4'hB: lit = 7'b0011111;
         4'hC: lit = 7'b1001110;  4'hD: lit = 7'b0111101;
         4'hE: lit = 7'b1001111;  default: lit = 7'b1000111;
      endcase
      return ~lit;
   endfunction

   task automatic check_now(input string req);
      int p, idx;
      logic [3:0] exp_an;
      logic [6:0] exp_sg;
      p = clr ? 0 : (((k + HALF) >> (TAP + 1)) & 3);
      idx = 3 - p;
      exp_an = dig_en[idx] ? (4'b0001 << idx) : 4'b0000;
      exp_sg = ref_seg(value[idx*4 +: 4]);
      n_chk++;
      if (anode !== exp_an || seg_n !== exp_sg) begin
         n_bad++;
         $display("FAIL %s k=%0d anode=%b exp %b seg_n=%b exp %b",
                  req, k, anode, exp_an, seg_n, exp_sg);
      end
   endtask

   task automatic t_reset();
      value = 16'hA5C3; dig_en = 4'b1111; clr = 1'b1;
      repeat (3) @(negedge clk);
      check_now("R1");
      clr = 1'b0;
   endtask

   // R2 R3 R6: full scan, every slot checked each cycle over several wraps
   task automatic t_scan_all();
      value = 16'h1234;
      for (int c = 0; c < 40; c++) begin
         @(negedge clk);
         check_now((c < 8) ? "R2" : "R3");
      end
      value = 16'hE07B;
      for (int c = 0; c < 40; c++) begin
         @(negedge clk);
         check_now("R6");
      end
   endtask

   // R4 R7: masked positions stay dark
   task automatic t_enable_mask();
      value = 16'h89AB;
      dig_en = 4'b0101;
      for (int c = 0; c < 36; c++) begin @(negedge clk); check_now("R4"); end
      dig_en = 4'b1010;
      for (int c = 0; c < 36; c++) begin @(negedge clk); check_now("R7"); end
      dig_en = 4'b0000;
      for (int c = 0; c < 36; c++) begin @(negedge clk); check_now("R4"); end
      dig_en = 4'b1111;
   endtask

   // R5: every hex value in whatever slot is current
   task automatic t_hex_all();
      for (int d = 0; d < 16; d++) begin
         @(negedge clk);
         #1 value = {4{4'(d)}};
         #1 check_now("R5");
      end
   endtask

   // R8: value and enable change inside a slot
   task automatic t_live();
      for (int c = 0; c < 12; c++) begin
         @(negedge clk);
         #1 value = value + 16'h1111;
         dig_en = {dig_en[2:0], dig_en[3]} ^ 4'b0010;
         #1 check_now("R8");
      end
      dig_en = 4'b1111;
   endtask

   // R1: clear acts between edges
   task automatic t_async_clear();
      value = 16'h4D2F;
      repeat (10) @(negedge clk);
      #1 clr = 1'b1;
      #1 check_now("R1");
      @(negedge clk);
      check_now("R1");
      clr = 1'b0;
      for (int c = 0; c < 12; c++) begin @(negedge clk); check_now("R2"); end
   endtask

   initial begin
      t_reset();
      t_scan_all();
      t_enable_mask();
      t_hex_all();
      t_live();
      t_async_clear();
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      #(200000 * 8);
      if (!done) begin
         done = 1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule